// File: doc/BRIEF.md
# Machine-check error bank recorder

This block keeps a set of hardware error-reporting banks for one processor. Each bank holds four 64-bit registers: a control mask, a status word, an error address and a miscellaneous word. Three global registers sit beside them: a capability word, a global control mask and a global status word. A one-bit machine-check enable register completes the set. Error sources present an error on an injection port. The block then decides, in one clock, whether to drop it, record it, only mark an overflow in the target bank, or give up and request shutdown.

Software reaches every register through a simple port. Reads are combinational. Writes take effect on the next clock edge. Recording an accepted uncorrected error raises a one-cycle machine-check interrupt. A request for shutdown is held until reset.

Top module: `mcr_top`

## Requirements
- R1: After a synchronous reset the registers hold the following values:
  - the capability word holds CAP_RESET (default 0x104: eight-bit bank count 4, control-present bit 8 set);
  - the global control and every bank control are all ones;
  - the global status, every bank status, every bank address, every bank misc and the enable bit are zero;
  - mc_irq and shutdown are low.
- R2: An injection into a bank index at or above capability bits [7:0] is rejected, and so is one at or above N_BANKS. A rejected injection changes no register and raises neither output.
- R3: An injection whose status bit 63 (valid) is clear is rejected, with no register change and no output.
- R4: While global status bit 2 (check in progress) is set, an injection is dropped when its status bit 55 (action required) is clear and inj_uncond is low. A dropped injection changes nothing. With inj_uncond high the same error is processed normally.
- R5: An uncorrected error (status bit 61 set) is dropped in either of two cases:
  - capability bit 8 is set and the global control is not all ones;
  - the target bank control is not all ones.
- R6: An uncorrected error that passes the filter of R5 records nothing when global status bit 2 is set or the enable bit is clear. In that case shutdown rises in the following cycle.
- R7: An uncorrected error that is accepted writes the bank address, the bank misc and the bank status, and copies inj_gstatus into the global status. The stored status is the injected status with bit 62 (overflow) forced to one if the bank status was already valid. mc_irq is high for exactly the cycle after the injection.
- R8: A corrected error (bit 61 clear) is handled according to the bank's current contents:
  - If the bank is not valid, or holds a status with bit 61 clear, the error overwrites the bank's status, address and misc. Bit 62 is set when the bank was valid.
  - Otherwise only bit 62 of the existing status is set, and the address and misc are kept.
  - In no case is there an interrupt.
- R9: The register port uses word addresses:
  - address 0 is the capability word;
  - address 1 is the global status;
  - address 2 is the global control;
  - address 3 is the enable bit, in bit 0;
  - bank b occupies addresses 4+4b to 7+4b, holding its control, status, address and misc in that order.
  Reads of unmapped addresses return zero and writes to them do nothing. A software write in a cycle with inj_valid high is ignored.
- R10: Once shutdown is high it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid | input | 1 | Injection request this cycle |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Bank status word to record |
| inj_gstatus | input | 64 | Global status to load on an uncorrected record |
| inj_addr | input | 64 | Error address word |
| inj_misc | input | 64 | Miscellaneous word |
| inj_uncond | input | 1 | Process even while a check is in progress |
| reg_we | input | 1 | Software write strobe |
| reg_waddr | input | ADDR_W | Software write word address |
| reg_wdata | input | 64 | Software write data |
| reg_raddr | input | ADDR_W | Software read word address |
| reg_rdata | output | 64 | Read data, combinational |
| mc_irq | output | 1 | One-cycle machine-check interrupt |
| shutdown | output | 1 | Sticky shutdown request |

## Verification
The assertions assume that the inputs are stable across each rising edge. They also assume that the block comes out of a synchronous reset held for at least one edge before any injection. The overflow and interrupt properties rely on software not writing a bank in the same cycle as an injection to it. The block itself discards such a write, and the stimulus only combines the two when it tests that discarding. The bench changes inputs at falling edges only, keeps each injection to a single cycle, and sequences the global registers by software writes between injections. This lets each rule be reached in isolation.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
package mcr_pkg;
    localparam int XLEN    = 64;
    localparam int CNT_W   = 8;
    localparam int ST_VAL  = 63;
    localparam int ST_OVF  = 62;
    localparam int ST_UC   = 61;
    localparam int ST_AR   = 55;
    localparam int GS_MCIP = 2;
    localparam int CAP_CTP = 8;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_REC_UC,
        ACT_REC_CE,
        ACT_OVF_ONLY,
        ACT_SHUT
    } act_e;

    function automatic word_t set_ovf(word_t s, logic was_valid);
        word_t r;
        r = s;
        if (was_valid) r[ST_OVF] = 1'b1;
        return r;
    endfunction

    function automatic logic is_record(act_e a);
        return (a == ACT_REC_UC) || (a == ACT_REC_CE);
    endfunction
endpackage

// File: rtl/mcr_decide.sv
`timescale 1ns/1ps
module mcr_decide
    import mcr_pkg::*;
(
    input  logic  accept,
    input  logic  uncond,
    input  word_t status,
    input  logic  ctl_present,
    input  word_t gctl,
    input  logic  mcip,
    input  logic  mce_en,
    input  word_t bctl,
    input  logic  bank_valid,
    input  logic  bank_uc,
    output act_e  act,
    output word_t new_status
);
    logic ao_drop;
    logic uc_filtered;

    assign ao_drop     = !uncond && !status[ST_AR] && mcip;
    assign uc_filtered = (ctl_present && (gctl != '1)) || (bctl != '1);
    assign new_status  = set_ovf(status, bank_valid);

    always_comb begin
        act = ACT_NONE;
        if (accept && !ao_drop) begin
            if (status[ST_UC]) begin
                if (uc_filtered)          act = ACT_NONE;
                else if (mcip || !mce_en) act = ACT_SHUT;
                else                      act = ACT_REC_UC;
            end else if (!bank_valid || !bank_uc) begin
                act = ACT_REC_CE;
            end else begin
                act = ACT_OVF_ONLY;
            end
        end
    end
endmodule

// File: rtl/mcr_bank.sv
`timescale 1ns/1ps
module mcr_bank
    import mcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  act_e       act,
    input  word_t      new_status,
    input  word_t      new_addr,
    input  word_t      new_misc,
    input  logic       sw_we,
    input  logic [1:0] sw_sel,
    input  word_t      sw_wdata,
    output word_t      ctl_o,
    output word_t      status_o,
    output word_t      addr_o,
    output word_t      misc_o
);
    word_t ctl_q, status_q, addr_q, misc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '1;
            status_q <= '0;
            addr_q   <= '0;
            misc_q   <= '0;
        end else if (hit && is_record(act)) begin
            status_q <= new_status;
            addr_q   <= new_addr;
            misc_q   <= new_misc;
        end else if (hit && act == ACT_OVF_ONLY) begin
            status_q[ST_OVF] <= 1'b1;
        end else if (sw_we) begin
            case (sw_sel)
                2'd0: ctl_q    <= sw_wdata;
                2'd1: status_q <= sw_wdata;
                2'd2: addr_q   <= sw_wdata;
                default: misc_q <= sw_wdata;
            endcase
        end
    end

    assign ctl_o    = ctl_q;
    assign status_o = status_q;
    assign addr_o   = addr_q;
    assign misc_o   = misc_q;

    // R8: overflow-only marking keeps address and misc
    p_ovf_only_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && act == ACT_OVF_ONLY) |=> (status_q[ST_OVF] && $stable(addr_q) && $stable(misc_q)));

    // R7: recording over a valid status leaves overflow set
    p_ovf_on_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && is_record(act) && status_q[ST_VAL]) |=> status_q[ST_OVF]);
endmodule

// File: rtl/mcr_top.sv
`timescale 1ns/1ps
module mcr_top
    import mcr_pkg::*;
#(
    parameter int           N_BANKS   = 4,
    parameter int           ADDR_W    = $clog2(4 + 4 * N_BANKS),
    parameter logic [63:0]  CAP_RESET = 64'h100 | 64'(N_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inj_valid,
    input  logic [7:0]        inj_bank,
    input  logic [63:0]       inj_status,
    input  logic [63:0]       inj_gstatus,
    input  logic [63:0]       inj_addr,
    input  logic [63:0]       inj_misc,
    input  logic              inj_uncond,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [63:0]       reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [63:0]       reg_rdata,
    output logic              mc_irq,
    output logic              shutdown
);
    localparam int IDX_W = ADDR_W - 2;

    word_t cap_q, gctl_q, gstat_q;
    logic  en_q, irq_q, shut_q;

    word_t b_ctl [N_BANKS];
    word_t b_st  [N_BANKS];
    word_t b_ad  [N_BANKS];
    word_t b_mi  [N_BANKS];

    logic  in_range, accept, sw_ok, sw_glob;
    word_t sel_ctl, sel_st, new_status;
    act_e  act;

    assign in_range = (inj_bank < cap_q[CNT_W-1:0]) && (32'(inj_bank) < N_BANKS);
    assign accept   = inj_valid && in_range && inj_status[ST_VAL];
    assign sw_ok    = reg_we && !inj_valid;
    assign sw_glob  = sw_ok && (reg_waddr[ADDR_W-1:2] == '0);

    always_comb begin
        sel_ctl = '1;
        sel_st  = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (32'(inj_bank) == b) begin
                sel_ctl = b_ctl[b];
                sel_st  = b_st[b];
            end
        end
    end

    mcr_decide u_decide (
        .accept      (accept),
        .uncond      (inj_uncond),
        .status      (inj_status),
        .ctl_present (cap_q[CAP_CTP]),
        .gctl        (gctl_q),
        .mcip        (gstat_q[GS_MCIP]),
        .mce_en      (en_q),
        .bctl        (sel_ctl),
        .bank_valid  (sel_st[ST_VAL]),
        .bank_uc     (sel_st[ST_UC]),
        .act         (act),
        .new_status  (new_status)
    );

    genvar g;
    generate
        for (g = 0; g < N_BANKS; g++) begin : g_bank
            mcr_bank u_bank (
                .clk        (clk),
                .rst        (rst),
                .hit        (32'(inj_bank) == g),
                .act        (act),
                .new_status (new_status),
                .new_addr   (inj_addr),
                .new_misc   (inj_misc),
                .sw_we      (sw_ok && (reg_waddr[ADDR_W-1:2] == IDX_W'(g + 1))),
                .sw_sel     (reg_waddr[1:0]),
                .sw_wdata   (reg_wdata),
                .ctl_o      (b_ctl[g]),
                .status_o   (b_st[g]),
                .addr_o     (b_ad[g]),
                .misc_o     (b_mi[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= CAP_RESET;
            gctl_q  <= '1;
            gstat_q <= '0;
            en_q    <= 1'b0;
            irq_q   <= 1'b0;
            shut_q  <= 1'b0;
        end else begin
            irq_q  <= (act == ACT_REC_UC);
            shut_q <= shut_q || (act == ACT_SHUT);
            if (act == ACT_REC_UC) begin
                gstat_q <= inj_gstatus;
            end else if (sw_glob) begin
                case (reg_waddr[1:0])
                    2'd0: cap_q   <= reg_wdata;
                    2'd1: gstat_q <= reg_wdata;
                    2'd2: gctl_q  <= reg_wdata;
                    default: en_q <= reg_wdata[0];
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr[ADDR_W-1:2] == '0) begin
            case (reg_raddr[1:0])
                2'd0: reg_rdata = cap_q;
                2'd1: reg_rdata = gstat_q;
                2'd2: reg_rdata = gctl_q;
                default: reg_rdata = {63'd0, en_q};
            endcase
        end
        for (int b = 0; b < N_BANKS; b++) begin
            if (reg_raddr[ADDR_W-1:2] == IDX_W'(b + 1)) begin
                case (reg_raddr[1:0])
                    2'd0: reg_rdata = b_ctl[b];
                    2'd1: reg_rdata = b_st[b];
                    2'd2: reg_rdata = b_ad[b];
                    default: reg_rdata = b_mi[b];
                endcase
            end
        end
    end

    assign mc_irq   = irq_q;
    assign shutdown = shut_q;

    // R7: an interrupt follows an uncorrected injection
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        mc_irq |-> ($past(inj_valid) && $past(inj_status[ST_UC])));

    // R2: out-of-range bank has no effect
    p_reject_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && (inj_bank >= cap_q[CNT_W-1:0])) |=> (!mc_irq && $stable(gstat_q) && !$rose(shutdown)));

    // R3: invalid status has no effect
    p_reject_inval_r3: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !inj_status[ST_VAL]) |=> (!mc_irq && $stable(gstat_q) && !$rose(shutdown)));

    // R4: action-optional error dropped while a check is in progress
    p_ao_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !inj_uncond && !inj_status[ST_AR] && gstat_q[GS_MCIP])
        |=> (!mc_irq && $stable(gstat_q) && !$rose(shutdown)));

    // R10: shutdown is sticky
    p_shut_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> shutdown);
endmodule

// File: tb/mcr_top_tb_top.sv
`timescale 1ns/1ps
module mcr_top_tb_top;
    localparam int N  = 4;
    localparam int AW = 5;
    localparam logic [63:0] CAP = 64'h104;
    localparam logic [63:0] VAL = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OVF = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UC  = 64'h2000_0000_0000_0000;
    localparam logic [63:0] AR  = 64'h0080_0000_0000_0000;
    localparam logic [63:0] ONES = '1;

    logic clk = 0;
    logic rst = 1;
    logic inj_valid = 0, inj_uncond = 0, reg_we = 0;
    logic [7:0]  inj_bank = 0;
    logic [63:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0, reg_wdata = 0;
    logic [AW-1:0] reg_waddr = 0, reg_raddr = 0;
    logic [63:0] reg_rdata;
    logic mc_irq, shutdown;

    always #2 clk = ~clk;

    mcr_top #(.N_BANKS(N)) dut_i (
        .clk(clk), .rst(rst), .inj_valid(inj_valid), .inj_bank(inj_bank),
        .inj_status(inj_status), .inj_gstatus(inj_gstatus), .inj_addr(inj_addr),
        .inj_misc(inj_misc), .inj_uncond(inj_uncond), .reg_we(reg_we),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata), .mc_irq(mc_irq), .shutdown(shutdown)
    );

    // behavioural reference state
    bit [63:0] m_ctl[N], m_st[N], m_ad[N], m_mi[N];
    bit [63:0] m_cap, m_gctl, m_gst;
    bit m_en, m_irq, m_shut;

    int vectors = 0, fails = 0, rot = 0;
    string cur_req = "R1";

    function automatic bit [63:0] m_read(int a);
        int b, k;
        if (a == 0) return m_cap;
        if (a == 1) return m_gst;
        if (a == 2) return m_gctl;
        if (a == 3) return {63'd0, m_en};
        if (a >= 4 + 4 * N) return 64'd0;
        b = (a - 4) / 4;
        k = (a - 4) % 4;
        case (k)
            0: return m_ctl[b];
            1: return m_st[b];
            2: return m_ad[b];
            default: return m_mi[b];
        endcase
    endfunction

    task automatic model_step();
        if (rst) begin
            m_cap = CAP; m_gctl = ONES; m_gst = 0; m_en = 0; m_irq = 0; m_shut = 0;
            for (int b = 0; b < N; b++) begin
                m_ctl[b] = ONES; m_st[b] = 0; m_ad[b] = 0; m_mi[b] = 0;
            end
        end else begin
            m_irq = 0;
            if (inj_valid) begin
                int b;
                bit [63:0] ns;
                b = int'(inj_bank);
                if (b < int'(m_cap[7:0]) && b < N && inj_status[63]) begin
                    ns = inj_status;
                    if (m_st[b][63]) ns[62] = 1;
                    if (!inj_uncond && !inj_status[55] && m_gst[2]) begin
                        // dropped
                    end else if (inj_status[61]) begin
                        if (m_cap[8] && m_gctl != ONES) begin
                        end else if (m_ctl[b] != ONES) begin
                        end else if (m_gst[2] || !m_en) begin
                            m_shut = 1;
                        end else begin
                            m_st[b] = ns; m_ad[b] = inj_addr; m_mi[b] = inj_misc;
                            m_gst = inj_gstatus; m_irq = 1;
                        end
                    end else if (!m_st[b][63] || !m_st[b][61]) begin
                        m_st[b] = ns; m_ad[b] = inj_addr; m_mi[b] = inj_misc;
                    end else begin
                        m_st[b][62] = 1;
                    end
                end
            end else if (reg_we) begin
                int a;
                a = int'(reg_waddr);
                if (a == 0) m_cap = reg_wdata;
                else if (a == 1) m_gst = reg_wdata;
                else if (a == 2) m_gctl = reg_wdata;
                else if (a == 3) m_en = reg_wdata[0];
                else if (a < 4 + 4 * N) begin
                    case ((a - 4) % 4)
                        0: m_ctl[(a - 4) / 4] = reg_wdata;
                        1: m_st[(a - 4) / 4]  = reg_wdata;
                        2: m_ad[(a - 4) / 4]  = reg_wdata;
                        default: m_mi[(a - 4) / 4] = reg_wdata;
                    endcase
                end
            end
        end
    endtask

    task automatic cmp(string req, string what, bit [63:0] act, bit [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: model follows the edge, then outputs are compared
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        reg_raddr = AW'(rot);
        #0.5;
        cmp(cur_req, "irq", {63'd0, mc_irq}, {63'd0, m_irq});
        cmp(cur_req, "shutdown", {63'd0, shutdown}, {63'd0, m_shut});
        cmp(cur_req, "rdata", reg_rdata, m_read(rot));
        rot = (rot + 1) % (4 + 4 * N + 1);
    endtask

    task automatic peek(string req, int a, bit [63:0] exp);
        reg_raddr = AW'(a);
        #0.5;
        cmp(req, "peek", reg_rdata, exp);
        cmp(req, "peek-model", reg_rdata, m_read(a));
    endtask

    task automatic inj(int b, bit [63:0] st, bit [63:0] gs, bit [63:0] ad, bit [63:0] mi, bit unc);
        inj_valid = 1; inj_bank = 8'(b); inj_status = st; inj_gstatus = gs;
        inj_addr = ad; inj_misc = mi; inj_uncond = unc;
        cyc();
        inj_valid = 0; inj_uncond = 0;
    endtask

    task automatic wr(int a, bit [63:0] d);
        reg_we = 1; reg_waddr = AW'(a); reg_wdata = d;
        cyc();
        reg_we = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        cyc(); cyc();
        rst = 0;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        cur_req = "R1";
        do_reset();
        peek("R1", 0, CAP);
        peek("R1", 2, ONES);
        peek("R1", 4, ONES);
        peek("R1", 5, 64'd0);
        peek("R1", 1, 64'd0);
        cmp("R1", "irq", {63'd0, mc_irq}, 64'd0);
        cmp("R1", "shutdown", {63'd0, shutdown}, 64'd0);
        for (int i = 0; i < 21; i++) cyc();

        cur_req = "R8";
        inj(0, VAL | 64'h11, 0, 64'h1000, 64'hA, 0);
        peek("R8", 5, VAL | 64'h11);
        peek("R8", 6, 64'h1000);
        inj(0, VAL | 64'h22, 0, 64'h2000, 64'hB, 0);
        peek("R8", 5, VAL | OVF | 64'h22);
        peek("R8", 7, 64'hB);

        cur_req = "R7";
        wr(3, 64'd1);
        inj(1, VAL | UC | AR | 64'h33, 64'h1, 64'h3000, 64'hC, 0);
        cmp("R7", "irq pulse", {63'd0, mc_irq}, 64'd1);
        cyc();
        cmp("R7", "irq low after", {63'd0, mc_irq}, 64'd0);
        peek("R7", 9, VAL | UC | AR | 64'h33);
        peek("R7", 1, 64'h1);
        cur_req = "R8";
        inj(1, VAL | 64'h11, 0, 64'h2222, 64'hD, 0);
        peek("R8", 9, VAL | OVF | UC | AR | 64'h33);
        peek("R8", 10, 64'h3000);
        cur_req = "R7";
        inj(1, VAL | UC | AR | 64'h44, 64'h1, 64'h4000, 64'hE, 0);
        peek("R7", 9, VAL | OVF | UC | AR | 64'h44);

        cur_req = "R2";
        inj(4, VAL | 64'h11, 0, 64'h5, 64'h5, 0);
        wr(0, 64'h102);
        inj(2, VAL | UC | AR | 64'h66, 64'h1, 64'h6, 64'h6, 0);
        cmp("R2", "irq", {63'd0, mc_irq}, 64'd0);
        peek("R2", 13, 64'd0);
        wr(0, CAP);

        cur_req = "R3";
        inj(2, 64'h11, 0, 64'h7, 64'h7, 0);
        peek("R3", 13, 64'd0);
        peek("R3", 14, 64'd0);

        cur_req = "R5";
        wr(12, 64'd0);
        inj(2, VAL | UC | AR | 64'h66, 64'h1, 64'h8, 64'h8, 0);
        cmp("R5", "irq bank ctl", {63'd0, mc_irq}, 64'd0);
        peek("R5", 13, 64'd0);
        wr(12, ONES);
        wr(2, 64'd0);
        inj(2, VAL | UC | AR | 64'h66, 64'h1, 64'h9, 64'h9, 0);
        peek("R5", 13, 64'd0);
        wr(0, 64'h004);
        inj(2, VAL | UC | AR | 64'h66, 64'h1, 64'hA, 64'hA, 0);
        cmp("R5", "irq ctl absent", {63'd0, mc_irq}, 64'd1);
        peek("R5", 13, VAL | UC | AR | 64'h66);
        wr(2, ONES);
        wr(0, CAP);

        cur_req = "R4";
        wr(1, 64'h4);
        inj(3, VAL | 64'h11, 0, 64'hB, 64'hB, 0);
        peek("R4", 17, 64'd0);
        inj(3, VAL | UC | 64'h55, 64'h1, 64'hC, 64'hC, 0);
        cmp("R4", "no shutdown", {63'd0, shutdown}, 64'd0);
        inj(3, VAL | 64'h11, 0, 64'hD, 64'hD, 1);
        peek("R4", 17, VAL | 64'h11);

        cur_req = "R6";
        inj(3, VAL | UC | AR | 64'h77, 64'h1, 64'hE, 64'hE, 0);
        cmp("R6", "shutdown", {63'd0, shutdown}, 64'd1);
        peek("R6", 17, VAL | 64'h11);

        cur_req = "R10";
        for (int i = 0; i < 5; i++) cyc();
        cmp("R10", "sticky", {63'd0, shutdown}, 64'd1);
        do_reset();
        cmp("R10", "cleared by reset", {63'd0, shutdown}, 64'd0);
        peek("R1", 5, 64'd0);

        cur_req = "R6";
        inj(0, VAL | UC | AR | 64'h88, 64'h1, 64'hF, 64'hF, 0);
        cmp("R6", "shutdown enable clear", {63'd0, shutdown}, 64'd1);
        peek("R6", 5, 64'd0);

        cur_req = "R9";
        reg_we = 1; reg_waddr = 5'd7; reg_wdata = 64'h1234;
        inj(0, 64'h11, 0, 64'h1, 64'h1, 0);
        reg_we = 0;
        peek("R9", 7, 64'd0);
        wr(7, 64'h1234);
        peek("R9", 7, 64'h1234);
        wr(20, 64'h55);
        peek("R9", 20, 64'd0);
        wr(3, 64'hFF);
        peek("R9", 3, 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule